// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block sits between a parallel flash bus and a program/erase sequencer. It watches chip-enable and write-enable pulses and turns each write into a command or data cycle. It holds a sticky read mode that sends read cycles to the array, the status byte or the signature codes. It also remembers whether a program or erase set-up is waiting for its second write. When a two-write instruction completes, or when a single-write control code arrives, the block raises a one-cycle request toward the sequencer. The request carries the target address and, for a program, the data.

The bus side is sampled on a system clock. One write event is taken per low pulse of the combined enable and write strobes. A power-down level input returns the interface to its idle state. A busy flag from the sequencer limits which commands are accepted while an operation runs. In byte organisation a byte-select input picks the half-word that a read returns or that a program writes.

Top module: `flash_cmd_if`

## Requirements
- R1: Writing low byte 0xFF selects array read (rd_mode 2'b00), 0x70 selects status read (2'b01) and 0x90 selects signature read (2'b10). The mode then stays in force for any number of reads.
- R2: In status mode a read returns seq_status on bits 7:0 with the upper bits zero. This also holds while seq_busy is high.
- R3: In signature mode a read returns 0x20 when addr[0] is 0. When addr[0] is 1 it returns 0xE0 if TOP_BOOT is 1 and 0xE6 if TOP_BOOT is 0. Every other address bit is ignored and the upper data bits are zero.
- R4: Writing 0x20 and then 0xD0 gives a one-cycle req_erase whose req_addr is the address of the 0xD0 write. After it the mode is status.
- R5: Writing 0x40 or 0x10 and then any data write gives a one-cycle req_prog with that write's address and data. In byte organisation the data is the low half, zero-extended, and req_hi equals byte_hi. After it the mode is status.
- R6: If the write after 0x20 is anything other than 0xD0, no request is raised, cmd_seq_err is set and the mode becomes status. Writing 0x50 clears cmd_seq_err and gives a one-cycle req_clr.
- R7: 0xB0 gives a one-cycle req_suspend. 0xD0 with no erase set-up pending gives a one-cycle req_resume.
- R8: Codes not listed in R1 to R7, 0x00 among them, change neither the mode nor any output.
- R9: Command decode uses only wdata[7:0]. The upper byte has no effect in word organisation.
- R10: While pd_n is low, rd_mode returns to array, any pending set-up and cmd_seq_err are cleared, and rdata is zero.
- R11: While seq_busy is high, only 0x70 and 0xB0 take effect, and only when no set-up is pending. All other writes are ignored.
- R12: rdata is zero unless cs_n and oe_n are low, we_n is high and pd_n is high. In byte organisation an array read returns the half-word chosen by byte_hi on the low bits.
- R13: At most one request is high at a time, and a write pulse held low for several cycles gives exactly one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Power-down level, low resets the interface |
| cs_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| word_mode | input | 1 | 1 = word organisation, 0 = byte organisation |
| byte_hi | input | 1 | Byte select in byte organisation |
| addr | input | ADDR_W | Bus address |
| wdata | input | DATA_W | Write data |
| arr_rdata | input | DATA_W | Word read from the array at addr |
| seq_status | input | 8 | Status byte kept by the sequencer |
| seq_busy | input | 1 | Sequencer is running an operation |
| rdata | output | DATA_W | Read data toward the bus |
| rd_mode | output | 2 | Current read mode |
| cmd_seq_err | output | 1 | Erase set-up was not confirmed |
| req_prog | output | 1 | Program request pulse |
| req_erase | output | 1 | Block erase request pulse |
| req_suspend | output | 1 | Erase suspend request pulse |
| req_resume | output | 1 | Erase resume request pulse |
| req_clr | output | 1 | Clear-status request pulse |
| req_addr | output | ADDR_W | Address for the request |
| req_data | output | DATA_W | Data for a program request |
| req_hi | output | 1 | Program targets the upper byte |

## Verification
A wrong read mode shows on the very next read cycle. The bench reads after every write, so the bad source on rdata is caught at once. A lost or wrong pending set-up stays hidden until the following write: a request that should pulse stays low, or one pulses where it should not. Requests and the error flag are therefore checked in the cycle after each write edge. A stale error flag or mode after power-down shows on rd_mode and cmd_seq_err one cycle after pd_n falls.

// File: rtl/flash_ci_pkg.sv
package flash_ci_pkg;

   typedef enum logic [1:0] {
      RM_ARRAY  = 2'b00,
      RM_STATUS = 2'b01,
      RM_SIG    = 2'b10
   } rd_mode_e;

   typedef enum logic [1:0] {
      PD_NONE  = 2'b00,
      PD_PROG  = 2'b01,
      PD_ERASE = 2'b10
   } pend_e;

   typedef struct packed {
      logic prog;
      logic erase;
      logic susp;
      logic resume;
      logic clr;
   } req_t;

   localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;
   localparam logic [7:0] OP_READ_STAT   = 8'h70;
   localparam logic [7:0] OP_READ_SIG    = 8'h90;
   localparam logic [7:0] OP_ERASE_SETUP = 8'h20;
   localparam logic [7:0] OP_PROG_SETUP  = 8'h40;
   localparam logic [7:0] OP_PROG_ALT    = 8'h10;
   localparam logic [7:0] OP_CLEAR       = 8'h50;
   localparam logic [7:0] OP_SUSPEND     = 8'hB0;
   localparam logic [7:0] OP_CONFIRM     = 8'hD0;

   localparam logic [7:0] SIG_MFR     = 8'h20;
   localparam logic [7:0] SIG_DEV_TOP = 8'hE0;
   localparam logic [7:0] SIG_DEV_BOT = 8'hE6;

endpackage

// File: rtl/ci_wr_detect.sv
module ci_wr_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic pd_n,
   input  logic cs_n,
   input  logic we_n,
   output logic wr_evt
);
   logic wr_act;
   logic wr_q;

   assign wr_act = pd_n & ~cs_n & ~we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_q <= 1'b0;
      else        wr_q <= wr_act;
   end

   // one event on the first cycle of each low pulse
   assign wr_evt = wr_act & ~wr_q;
endmodule

// File: rtl/ci_cmd_ctrl.sv
module ci_cmd_ctrl
   import flash_ci_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pd_n,
   input  logic              wr_evt,
   input  logic              busy,
   input  logic              word_mode,
   input  logic              byte_hi,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output rd_mode_e          mode,
   output req_t              req,
   output logic [ADDR_W-1:0] req_addr,
   output logic [DATA_W-1:0] req_data,
   output logic              req_hi,
   output logic              seq_err
);
   localparam int HALF = DATA_W / 2;

   pend_e             pend_q;
   logic [7:0]        cmd;
   logic              accept;
   logic [DATA_W-1:0] prog_data;

   assign cmd = wdata[7:0];

   // busy sequencer: only status read and suspend, never mid-pair
   assign accept = ~busy |
                   ((pend_q == PD_NONE) &&
                    ((cmd == OP_READ_STAT) || (cmd == OP_SUSPEND)));

   assign prog_data = word_mode ? wdata : {{HALF{1'b0}}, wdata[HALF-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode     <= RM_ARRAY;
         pend_q   <= PD_NONE;
         req      <= '0;
         req_addr <= '0;
         req_data <= '0;
         req_hi   <= 1'b0;
         seq_err  <= 1'b0;
      end else if (!pd_n) begin
         mode    <= RM_ARRAY;
         pend_q  <= PD_NONE;
         req     <= '0;
         seq_err <= 1'b0;
      end else begin
         req <= '0;
         if (wr_evt && accept) begin
            unique case (pend_q)
               PD_PROG: begin
                  req.prog <= 1'b1;
                  req_addr <= addr;
                  req_data <= prog_data;
                  req_hi   <= ~word_mode & byte_hi;
                  mode     <= RM_STATUS;
                  pend_q   <= PD_NONE;
               end
               PD_ERASE: begin
                  pend_q <= PD_NONE;
                  mode   <= RM_STATUS;
                  if (cmd == OP_CONFIRM) begin
                     req.erase <= 1'b1;
                     req_addr  <= addr;
                  end else begin
                     seq_err <= 1'b1;
                  end
               end
               default: begin
                  unique case (cmd)
                     OP_READ_ARRAY:  mode   <= RM_ARRAY;
                     OP_READ_STAT:   mode   <= RM_STATUS;
                     OP_READ_SIG:    mode   <= RM_SIG;
                     OP_ERASE_SETUP: pend_q <= PD_ERASE;
                     OP_PROG_SETUP,
                     OP_PROG_ALT:    pend_q <= PD_PROG;
                     OP_CLEAR: begin
                        req.clr <= 1'b1;
                        seq_err <= 1'b0;
                     end
                     OP_SUSPEND:     req.susp   <= 1'b1;
                     OP_CONFIRM:     req.resume <= 1'b1;
                     default:        ;
                  endcase
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/ci_rd_steer.sv
module ci_rd_steer
   import flash_ci_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter bit TOP_BOOT = 1'b1
) (
   input  rd_mode_e          mode,
   input  logic              rd_en,
   input  logic              word_mode,
   input  logic              byte_hi,
   input  logic              sig_a0,
   input  logic [DATA_W-1:0] arr_rdata,
   input  logic [7:0]        status,
   output logic [DATA_W-1:0] rdata
);
   localparam int HALF = DATA_W / 2;

   logic [7:0]        dev_code;
   logic [DATA_W-1:0] arr_view;
   logic [DATA_W-1:0] sel;

   generate
      if (TOP_BOOT) begin : g_top_boot
         assign dev_code = SIG_DEV_TOP;
      end else begin : g_bot_boot
         assign dev_code = SIG_DEV_BOT;
      end
   endgenerate

   assign arr_view = word_mode ? arr_rdata :
                     {{HALF{1'b0}}, (byte_hi ? arr_rdata[DATA_W-1:HALF]
                                             : arr_rdata[HALF-1:0])};

   always_comb begin
      sel = '0;
      unique case (mode)
         RM_ARRAY:  sel = arr_view;
         RM_STATUS: sel[7:0] = status;
         RM_SIG:    sel[7:0] = sig_a0 ? dev_code : SIG_MFR;
         default:   sel = '0;
      endcase
   end

   assign rdata = rd_en ? sel : '0;
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
   import flash_ci_pkg::*;
#(
   parameter int ADDR_W   = 17,
   parameter int DATA_W   = 16,
   parameter bit TOP_BOOT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pd_n,
   input  logic              cs_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic              word_mode,
   input  logic              byte_hi,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] arr_rdata,
   input  logic [7:0]        seq_status,
   input  logic              seq_busy,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        rd_mode,
   output logic              cmd_seq_err,
   output logic              req_prog,
   output logic              req_erase,
   output logic              req_suspend,
   output logic              req_resume,
   output logic              req_clr,
   output logic [ADDR_W-1:0] req_addr,
   output logic [DATA_W-1:0] req_data,
   output logic              req_hi
);
   generate
      if (DATA_W < 16 || (DATA_W % 2) != 0) begin : g_bad_data_w
         $error("flash_cmd_if: DATA_W must be even and at least 16");
      end
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("flash_cmd_if: ADDR_W must be at least 2");
      end
   endgenerate

   logic     wr_evt;
   logic     rd_en;
   rd_mode_e mode;
   req_t     req;

   ci_wr_detect u_wr (
      .clk    (clk),
      .rst_n  (rst_n),
      .pd_n   (pd_n),
      .cs_n   (cs_n),
      .we_n   (we_n),
      .wr_evt (wr_evt)
   );

   ci_cmd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .pd_n      (pd_n),
      .wr_evt    (wr_evt),
      .busy      (seq_busy),
      .word_mode (word_mode),
      .byte_hi   (byte_hi),
      .addr      (addr),
      .wdata     (wdata),
      .mode      (mode),
      .req       (req),
      .req_addr  (req_addr),
      .req_data  (req_data),
      .req_hi    (req_hi),
      .seq_err   (cmd_seq_err)
   );

   assign rd_en = pd_n & ~cs_n & ~oe_n & we_n;

   ci_rd_steer #(.DATA_W(DATA_W), .TOP_BOOT(TOP_BOOT)) u_rd (
      .mode      (mode),
      .rd_en     (rd_en),
      .word_mode (word_mode),
      .byte_hi   (byte_hi),
      .sig_a0    (addr[0]),
      .arr_rdata (arr_rdata),
      .status    (seq_status),
      .rdata     (rdata)
   );

   assign rd_mode     = mode;
   assign req_prog    = req.prog;
   assign req_erase   = req.erase;
   assign req_suspend = req.susp;
   assign req_resume  = req.resume;
   assign req_clr     = req.clr;
endmodule

// File: rtl/flash_cmd_if_chk.sv
module flash_cmd_if_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pd_n,
   input logic              cs_n,
   input logic              we_n,
   input logic              oe_n,
   input logic              seq_busy,
   input logic [7:0]        seq_status,
   input logic [DATA_W-1:0] rdata,
   input logic [1:0]        rd_mode,
   input logic              cmd_seq_err,
   input logic              req_prog,
   input logic              req_erase,
   input logic              req_suspend,
   input logic              req_resume,
   input logic              req_clr
);
   logic any_req;
   logic rd_cycle;

   assign any_req  = req_prog | req_erase | req_suspend | req_resume | req_clr;
   assign rd_cycle = pd_n & ~cs_n & ~oe_n & we_n;

   assert_req_onehot_R13: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req_prog, req_erase, req_suspend, req_resume, req_clr}));

   assert_req_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
      any_req |=> !any_req);

   assert_pd_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !pd_n |=> (rd_mode == 2'b00) && !cmd_seq_err && !any_req);

   assert_start_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_prog || req_erase) |-> (rd_mode == 2'b01));

   assert_err_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_seq_err) |-> (rd_mode == 2'b01) && !any_req);

   assert_busy_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_prog || req_erase || req_resume || req_clr) |-> !$past(seq_busy));

   assert_idle_bus_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_cycle |-> (rdata == '0));

   assert_status_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cycle && rd_mode == 2'b01) |-> (rdata == {{(DATA_W-8){1'b0}}, seq_status}));
endmodule

bind flash_cmd_if flash_cmd_if_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pd_n        (pd_n),
   .cs_n        (cs_n),
   .we_n        (we_n),
   .oe_n        (oe_n),
   .seq_busy    (seq_busy),
   .seq_status  (seq_status),
   .rdata       (rdata),
   .rd_mode     (rd_mode),
   .cmd_seq_err (cmd_seq_err),
   .req_prog    (req_prog),
   .req_erase   (req_erase),
   .req_suspend (req_suspend),
   .req_resume  (req_resume),
   .req_clr     (req_clr)
);

// File: tb/tb_flash_cmd_if.sv
`timescale 1ns/1ps
module tb_flash_cmd_if;
   localparam int AW = 17;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pd_n = 1'b1;
   logic          cs_n = 1'b1;
   logic          we_n = 1'b1;
   logic          oe_n = 1'b1;
   logic          word_mode = 1'b1;
   logic          byte_hi = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] arr_rdata;
   logic [7:0]    seq_status = 8'h80;
   logic          seq_busy = 1'b0;
   logic [DW-1:0] rdata;
   logic [1:0]    rd_mode;
   logic          cmd_seq_err;
   logic          req_prog, req_erase, req_suspend, req_resume, req_clr;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_data;
   logic          req_hi;

   int compared = 0;
   int mismatched = 0;

   always #2.5 clk = ~clk;

   // array model: low byte is addr, high byte is addr xor 0x5A
   assign arr_rdata = {addr[7:0] ^ 8'h5A, addr[7:0]};

   flash_cmd_if dut (
      .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .cs_n(cs_n), .we_n(we_n),
      .oe_n(oe_n), .word_mode(word_mode), .byte_hi(byte_hi), .addr(addr),
      .wdata(wdata), .arr_rdata(arr_rdata), .seq_status(seq_status),
      .seq_busy(seq_busy), .rdata(rdata), .rd_mode(rd_mode),
      .cmd_seq_err(cmd_seq_err), .req_prog(req_prog), .req_erase(req_erase),
      .req_suspend(req_suspend), .req_resume(req_resume), .req_clr(req_clr),
      .req_addr(req_addr), .req_data(req_data), .req_hi(req_hi)
   );

   typedef struct packed {
      logic          busy;
      logic [15:0]   wd;
      logic [AW-1:0] ad;
      logic [4:0]    ereq;   // prog, erase, suspend, resume, clr
      logic [1:0]    emode;
      logic          eerr;
      logic [AW-1:0] rad;
      logic [15:0]   erd;
      logic [AW-1:0] eaddr;
      logic [15:0]   edata;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 16'h00FF, 17'h00010, 5'b00000, 2'd0, 1'b0, 17'h00034, 16'h6E34, 17'h0, 16'h0},
      '{1'b0, 16'h1290, 17'h00000, 5'b00000, 2'd2, 1'b0, 17'h1FFF0, 16'h0020, 17'h0, 16'h0},
      '{1'b0, 16'h0000, 17'h00000, 5'b00000, 2'd2, 1'b0, 17'h00001, 16'h00E0, 17'h0, 16'h0},
      '{1'b0, 16'h0070, 17'h00000, 5'b00000, 2'd1, 1'b0, 17'h00000, 16'h0080, 17'h0, 16'h0},
      '{1'b0, 16'h0040, 17'h00000, 5'b00000, 2'd1, 1'b0, 17'h00000, 16'h0080, 17'h0, 16'h0},
      '{1'b0, 16'hABCD, 17'h00123, 5'b10000, 2'd1, 1'b0, 17'h00000, 16'h0080, 17'h00123, 16'hABCD},
      '{1'b0, 16'h00FF, 17'h00000, 5'b00000, 2'd0, 1'b0, 17'h00002, 16'h5802, 17'h0, 16'h0},
      '{1'b0, 16'h0020, 17'h00000, 5'b00000, 2'd0, 1'b0, 17'h00002, 16'h5802, 17'h0, 16'h0},
      '{1'b0, 16'h00D0, 17'h0C000, 5'b01000, 2'd1, 1'b0, 17'h00000, 16'h0080, 17'h0C000, 16'h0},
      '{1'b0, 16'h00B0, 17'h00000, 5'b00100, 2'd1, 1'b0, 17'h00000, 16'h0080, 17'h0, 16'h0},
      '{1'b0, 16'h00D0, 17'h00000, 5'b00010, 2'd1, 1'b0, 17'h00000, 16'h0080, 17'h0, 16'h0},
      '{1'b0, 16'h0010, 17'h00000, 5'b00000, 2'd1, 1'b0, 17'h00000, 16'h0080, 17'h0, 16'h0},
      '{1'b0, 16'h5555, 17'h00077, 5'b10000, 2'd1, 1'b0, 17'h00000, 16'h0080, 17'h00077, 16'h5555},
      '{1'b0, 16'h0020, 17'h00000, 5'b00000, 2'd1, 1'b0, 17'h00000, 16'h0080, 17'h0, 16'h0},
      '{1'b0, 16'h00FF, 17'h00000, 5'b00000, 2'd1, 1'b1, 17'h00000, 16'h0080, 17'h0, 16'h0},
      '{1'b0, 16'h0050, 17'h00000, 5'b00001, 2'd1, 1'b0, 17'h00000, 16'h0080, 17'h0, 16'h0},
      '{1'b0, 16'h0033, 17'h00000, 5'b00000, 2'd1, 1'b0, 17'h00000, 16'h0080, 17'h0, 16'h0},
      '{1'b1, 16'h00FF, 17'h00000, 5'b00000, 2'd1, 1'b0, 17'h00000, 16'h0080, 17'h0, 16'h0},
      '{1'b1, 16'h0090, 17'h00000, 5'b00000, 2'd1, 1'b0, 17'h00000, 16'h0080, 17'h0, 16'h0},
      '{1'b1, 16'h00B0, 17'h00000, 5'b00100, 2'd1, 1'b0, 17'h00000, 16'h0080, 17'h0, 16'h0},
      '{1'b1, 16'h0040, 17'h00000, 5'b00000, 2'd1, 1'b0, 17'h00000, 16'h0080, 17'h0, 16'h0},
      '{1'b0, 16'h8890, 17'h00000, 5'b00000, 2'd2, 1'b0, 17'h00003, 16'h00E0, 17'h0, 16'h0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] d, input logic [AW-1:0] a);
      @(negedge clk);
      cs_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
      @(negedge clk);
      cs_n = 1'b1; we_n = 1'b1;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] r);
      @(negedge clk);
      cs_n = 1'b0; oe_n = 1'b0; addr = a;
      #1;
      r = rdata;
      cs_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   initial begin
      #(5.0 * 150000);
      mismatched++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [DW-1:0] r;
      int cnt;
      repeat (3) @(negedge clk);
      // reset state, R10 and R12
      chk("R10 reset mode", {30'd0, rd_mode}, 32'd0);
      chk("R10 reset err", {31'd0, cmd_seq_err}, 32'd0);
      chk("R12 reset rdata", {16'd0, rdata}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // table walk: R1-R9, R11, R13
      for (int i = 0; i < NV; i++) begin
         seq_busy = VEC[i].busy;
         wr(VEC[i].wd, VEC[i].ad);
         chk($sformatf("R1-table %0d req (R4 R5 R6 R7 R8 R11)", i),
             {27'd0, req_prog, req_erase, req_suspend, req_resume, req_clr},
             {27'd0, VEC[i].ereq});
         chk($sformatf("R1 table %0d mode", i), {30'd0, rd_mode}, {30'd0, VEC[i].emode});
         chk($sformatf("R6 table %0d err", i), {31'd0, cmd_seq_err}, {31'd0, VEC[i].eerr});
         if (VEC[i].ereq[4] || VEC[i].ereq[3])
            chk($sformatf("R4 table %0d addr", i), {15'd0, req_addr}, {15'd0, VEC[i].eaddr});
         if (VEC[i].ereq[4])
            chk($sformatf("R5 table %0d data", i), {16'd0, req_data}, {16'd0, VEC[i].edata});
         rd(VEC[i].rad, r);
         chk($sformatf("R2 R3 table %0d rdata", i), {16'd0, r}, {16'd0, VEC[i].erd});
      end
      seq_busy = 1'b0;

      // R12: output enable high gives zero
      wr(16'h00FF, '0);
      @(negedge clk);
      cs_n = 1'b0; addr = 17'h00034; #1;
      chk("R12 oe high", {16'd0, rdata}, 32'd0);
      cs_n = 1'b1;

      // R12: byte organisation array read
      word_mode = 1'b0; byte_hi = 1'b1;
      rd(17'h00034, r);
      chk("R12 byte hi", {16'd0, r}, 32'h0000006E);
      byte_hi = 1'b0;
      rd(17'h00034, r);
      chk("R12 byte lo", {16'd0, r}, 32'h00000034);

      // R5: byte program data and lane
      byte_hi = 1'b1;
      wr(16'h0040, '0);
      wr(16'hFFA5, 17'h00042);
      chk("R5 byte prog req", {31'd0, req_prog}, 32'd1);
      chk("R5 byte prog data", {16'd0, req_data}, 32'h000000A5);
      chk("R5 byte prog hi", {31'd0, req_hi}, 32'd1);
      word_mode = 1'b1; byte_hi = 1'b0;

      // R13: long write pulse gives one request
      wr(16'h0010, '0);
      @(negedge clk);
      cs_n = 1'b0; we_n = 1'b0; addr = 17'h00005; wdata = 16'h1234;
      cnt = 0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         cnt += int'(req_prog);
      end
      cs_n = 1'b1; we_n = 1'b1;
      chk("R13 held pulse count", cnt, 32'd1);

      // R10: power-down clears error and mode, rdata zero
      wr(16'h0020, '0);
      wr(16'h0011, '0);
      chk("R6 err set", {31'd0, cmd_seq_err}, 32'd1);
      @(negedge clk);
      pd_n = 1'b0; cs_n = 1'b0; oe_n = 1'b0; #1;
      chk("R10 pd rdata", {16'd0, rdata}, 32'd0);
      @(negedge clk);
      chk("R10 pd mode", {30'd0, rd_mode}, 32'd0);
      chk("R10 pd err", {31'd0, cmd_seq_err}, 32'd0);
      pd_n = 1'b1; cs_n = 1'b1; oe_n = 1'b1;

      // R10: pending set-up dropped by power-down
      wr(16'h0040, '0);
      @(negedge clk); pd_n = 1'b0;
      @(negedge clk); pd_n = 1'b1;
      wr(16'h0090, '0);
      chk("R10 pending cleared", {31'd0, req_prog}, 32'd0);
      chk("R10 post pd decode", {30'd0, rd_mode}, 32'd2);

      summary();
      $finish;
   end
endmodule